// File: doc/BRIEF.md
# MESI Coherence Line Controller

This block keeps the coherence state of every line of a small direct-mapped cache. Each line holds one data word. The block serves two sources of events. The first is the local processor, which issues reads and writes. The second is the shared bus, where the block watches the messages sent by the other caches. For each event it updates the line's state, tag and data. It also emits the bus messages that the MESI protocol calls for.

Each line's state is 2 bits wide, encoded Invalid = 2'b00, Shared = 2'b01, Exclusive = 2'b10 and Modified = 2'b11. Bus message codes are 3 bits wide:

| Code | Message |
|------|---------|
| 0 | read |
| 1 | read response |
| 2 | invalidate |
| 3 | invalidate acknowledge |
| 4 | read-invalidate |
| 5 | writeback |

The block's own requests go out on a request channel. That channel waits for a grant from an external arbiter. Replies to snooped messages leave one cycle later on two dedicated lanes, one for acknowledgements and one for data responses. The low `IDXW` address bits select the line and the remaining bits form the tag. Only one local miss or upgrade may be outstanding at a time.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high and no bus, acknowledge or data-response output is active. The first access to any index therefore misses.
- R2: A read that hits a valid line with a matching tag sends no bus message. It returns the stored word with `cpu_done` one cycle after acceptance.
- R3: A read miss sends a read message (code 0) for the requested address. It then waits for a read response (code 1) to that address. The line is installed as Exclusive when `in_shared` is 0 and as Shared when it is 1, and the response data is returned.
- R4: A write that hits an Exclusive or Modified line sends no bus message. It stores the word, leaves the line Modified and raises `cpu_done` one cycle after acceptance.
- R5: A write that hits a Shared line sends an invalidate (code 2) for the address. It completes only after `NPEER` acknowledgements (code 3) for that address have arrived. The line then ends Modified with the new word.
- R6: A write miss sends a read-invalidate (code 4). It completes only after both a read response and `NPEER` acknowledgements have arrived, in either order. The line is then installed as Modified holding the written word.
- R7: Before the miss request, a miss whose victim line is Modified sends a writeback (code 5) carrying the victim's full address and data. Exclusive and Shared victims are dropped without any message.
- R8: A snooped read that hits a Modified line produces a data response one cycle later with the line's address and word, and the line becomes Shared. A hit on an Exclusive line makes it Shared without a data response.
- R9: Every snooped invalidate or read-invalidate is acknowledged one cycle later with its address, whether or not the line is held. A held matching line drops to Invalid. A read-invalidate that hits a Modified line also produces a data response with the word.
- R10: From the acceptance of a miss or upgrade until its `cpu_done`, `cpu_ready` stays low. Snooped messages are still serviced during that time.
- R11: A request message appears on `out_valid` only in a cycle where `bus_req` and `bus_gnt` are both high. `bus_req` stays high until the grant arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Local access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Local access address |
| cpu_wdata | input | DW | Local write word |
| cpu_ready | output | 1 | Block can accept a local request this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Word returned on completion |
| bus_req | output | 1 | Request for the bus |
| bus_gnt | input | 1 | Bus grant |
| out_valid | output | 1 | Outgoing request message valid |
| out_type | output | 3 | Outgoing message code |
| out_addr | output | AW | Outgoing message address |
| out_data | output | DW | Writeback data (zero for other messages) |
| in_valid | input | 1 | Incoming bus message valid |
| in_type | input | 3 | Incoming message code |
| in_addr | input | AW | Incoming message address |
| in_data | input | DW | Data carried by a read response |
| in_shared | input | 1 | With a read response: another cache keeps a copy |
| ack_valid | output | 1 | Invalidate acknowledge issued |
| ack_addr | output | AW | Address being acknowledged |
| dresp_valid | output | 1 | Data response issued for a snoop |
| dresp_addr | output | AW | Data response address |
| dresp_data | output | DW | Data response word |

## Verification
Every line index is driven through a fixed walk that moves a line through all four states. The walk uses read and write hits, misses with Modified, Exclusive and Shared victims, upgrades, and each kind of snoop. The line state is never read directly. It is inferred from the traffic the next access produces:
- a write hit that is silent shows Exclusive or Modified;
- an invalidate shows Shared;
- a new read message shows Invalid;
- a data response to a snooped read shows Modified.

Read-invalidate responses arrive data-first on some indices and acknowledge-first on others. Grants are delayed by different numbers of cycles on different indices. A foreign invalidate is injected during a pending miss, which shows whether snoops are serviced while the processor is stalled.

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int IDXW  = 2,
  parameter int NPEER = 2
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          out_valid,
  output logic [2:0]    out_type,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  input  logic          in_valid,
  input  logic [2:0]    in_type,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic          in_shared,
  output logic          ack_valid,
  output logic [AW-1:0] ack_addr,
  output logic          dresp_valid,
  output logic [AW-1:0] dresp_addr,
  output logic [DW-1:0] dresp_data
);
  localparam int NL = 1 << IDXW;
  localparam int TW = AW - IDXW;
  localparam int CW = $clog2(NPEER + 1);
  localparam logic [1:0] ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11;
  localparam logic [2:0] MSG_RD = 3'd0, MSG_RESP = 3'd1, MSG_INV = 3'd2,
                         MSG_ACK = 3'd3, MSG_RDINV = 3'd4, MSG_WB = 3'd5;

  typedef enum logic [1:0] {F_IDLE, F_EVICT, F_ISSUE, F_WAIT} fsm_t;

  logic [1:0]    st  [NL];
  logic [TW-1:0] tg  [NL];
  logic [DW-1:0] dat [NL];
  fsm_t          fsm;
  logic          p_we;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wdata;
  logic [2:0]    p_type;
  logic          got_data, got_shared;
  logic [DW-1:0] got_word;
  logic [CW-1:0] acks;

  wire [IDXW-1:0] c_idx = cpu_addr[IDXW-1:0];
  wire [IDXW-1:0] s_idx = in_addr[IDXW-1:0];
  wire [IDXW-1:0] p_idx = p_addr[IDXW-1:0];
  wire c_hit   = st[c_idx] != ST_I && tg[c_idx] == cpu_addr[AW-1:IDXW];
  wire s_hit   = st[s_idx] != ST_I && tg[s_idx] == in_addr[AW-1:IDXW];
  wire accept  = cpu_req && cpu_ready;
  wire snp_rd  = in_valid && in_type == MSG_RD;
  wire snp_inv = in_valid && (in_type == MSG_INV || in_type == MSG_RDINV);
  wire for_me  = in_valid && in_addr == p_addr;
  wire need_data = p_type != MSG_INV;
  wire need_acks = p_type != MSG_RD;
  wire fin = fsm == F_WAIT && (got_data || !need_data) &&
             (acks == CW'(NPEER) || !need_acks);
  wire victim_m = st[p_idx] == ST_M;

  assign cpu_ready = fsm == F_IDLE && !in_valid;
  assign bus_req   = (fsm == F_EVICT && victim_m) || fsm == F_ISSUE;
  assign out_valid = bus_req && bus_gnt;
  assign out_type  = fsm == F_EVICT ? MSG_WB : p_type;
  assign out_addr  = fsm == F_EVICT ? {tg[p_idx], p_idx} : p_addr;
  assign out_data  = fsm == F_EVICT ? dat[p_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) begin
        st[i]  <= ST_I;
        tg[i]  <= '0;
        dat[i] <= '0;
      end
      fsm <= F_IDLE;
      p_we <= 1'b0; p_addr <= '0; p_wdata <= '0; p_type <= MSG_RD;
      got_data <= 1'b0; got_shared <= 1'b0; got_word <= '0; acks <= '0;
      cpu_done <= 1'b0; cpu_rdata <= '0;
      ack_valid <= 1'b0; ack_addr <= '0;
      dresp_valid <= 1'b0; dresp_addr <= '0; dresp_data <= '0;
    end else begin
      cpu_done    <= 1'b0;
      ack_valid   <= snp_inv;
      ack_addr    <= in_addr;
      dresp_valid <= 1'b0;
      dresp_addr  <= in_addr;
      dresp_data  <= dat[s_idx];

      if (in_valid && s_hit) begin
        if (snp_rd) begin
          if (st[s_idx] == ST_M) dresp_valid <= 1'b1;
          st[s_idx] <= ST_S;
        end else if (snp_inv) begin
          if (in_type == MSG_RDINV && st[s_idx] == ST_M) dresp_valid <= 1'b1;
          st[s_idx] <= ST_I;
        end
      end

      case (fsm)
        F_IDLE: if (accept) begin
          p_we    <= cpu_we;
          p_addr  <= cpu_addr;
          p_wdata <= cpu_wdata;
          if (c_hit) begin
            if (!cpu_we) begin
              cpu_done  <= 1'b1;
              cpu_rdata <= dat[c_idx];
            end else if (st[c_idx] == ST_S) begin
              p_type <= MSG_INV;
              fsm    <= F_ISSUE;
            end else begin
              st[c_idx]  <= ST_M;
              dat[c_idx] <= cpu_wdata;
              cpu_done   <= 1'b1;
              cpu_rdata  <= cpu_wdata;
            end
          end else begin
            p_type <= cpu_we ? MSG_RDINV : MSG_RD;
            fsm    <= st[c_idx] == ST_M ? F_EVICT : F_ISSUE;
          end
        end
        F_EVICT: begin
          if (!victim_m) fsm <= F_ISSUE;
          else if (bus_gnt) begin
            st[p_idx] <= ST_I;
            fsm       <= F_ISSUE;
          end
        end
        F_ISSUE: if (bus_gnt) begin
          fsm        <= F_WAIT;
          got_data   <= 1'b0;
          got_shared <= 1'b0;
          acks       <= '0;
        end
        F_WAIT: begin
          if (fin) begin
            tg[p_idx] <= p_addr[AW-1:IDXW];
            if (p_we) begin
              st[p_idx]  <= ST_M;
              dat[p_idx] <= p_wdata;
              cpu_rdata  <= p_wdata;
            end else begin
              st[p_idx]  <= got_shared ? ST_S : ST_E;
              dat[p_idx] <= got_word;
              cpu_rdata  <= got_word;
            end
            cpu_done <= 1'b1;
            fsm      <= F_IDLE;
          end else begin
            if (for_me && in_type == MSG_RESP && !got_data) begin
              got_data   <= 1'b1;
              got_word   <= in_data;
              got_shared <= in_shared;
            end
            if (for_me && in_type == MSG_ACK && acks != CW'(NPEER))
              acks <= acks + 1'b1;
          end
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  assert_exclusive_write_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cpu_we && c_hit && st[c_idx] == ST_E |=> cpu_done && !bus_req);

  assert_snoop_inv_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inv && s_hit && fsm != F_WAIT |=> st[$past(s_idx)] == ST_I);

  assert_dresp_from_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dresp_valid |-> $past(in_valid && (in_type == MSG_RD || in_type == MSG_RDINV)));

  assert_miss_stalls_cpu_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_type == MSG_RD || out_type == MSG_RDINV) |=> !cpu_ready && !cpu_done);

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && !in_valid |=> bus_req);
endmodule

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb_top;
  localparam int AW = 8, DW = 16, IDXW = 2, NPEER = 2;
  localparam logic [2:0] M_RD = 3'd0, M_RESP = 3'd1, M_INV = 3'd2,
                         M_ACK = 3'd3, M_RDINV = 3'd4, M_WB = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready, cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req, bus_gnt = 0, out_valid;
  logic [2:0]    out_type;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic          in_valid = 0, in_shared = 0;
  logic [2:0]    in_type = '0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic          ack_valid, dresp_valid;
  logic [AW-1:0] ack_addr, dresp_addr;
  logic [DW-1:0] dresp_data;

  mesi_line_ctrl #(.AW(AW), .DW(DW), .IDXW(IDXW), .NPEER(NPEER)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .out_valid(out_valid), .out_type(out_type),
    .out_addr(out_addr), .out_data(out_data),
    .in_valid(in_valid), .in_type(in_type), .in_addr(in_addr), .in_data(in_data),
    .in_shared(in_shared),
    .ack_valid(ack_valid), .ack_addr(ack_addr),
    .dresp_valid(dresp_valid), .dresp_addr(dresp_addr), .dresp_data(dresp_data));

  int nvec = 0, nerr = 0;
  logic [2:0]    lt [4];
  logic [AW-1:0] la [4];
  logic [DW-1:0] ld [4];
  int            nmsg;
  logic [DW-1:0] rdv;
  bit            fin_o, rdy_leak, hold_fail, inj_ack;
  logic          sav, sdv;
  logic [AW-1:0] saa;
  logic [DW-1:0] sdd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input logic sh, input logic [DW-1:0] rsp, input bit ackfirst,
                       input int gdelay, input bit inj, input logic [AW-1:0] inj_a);
    logic [2:0]    sq_t [6];
    logic [AW-1:0] sq_a [6];
    int sq_n = 0, sq_i = 0, waited = 0;
    bit waiting = 0, chk_ack = 0;
    nmsg = 0; fin_o = 0; rdy_leak = 0; hold_fail = 0; inj_ack = 0; rdv = '0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; in_valid = 0; bus_gnt = 0;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cpu_req = 0;
    for (int c = 0; c < 80 && !fin_o; c++) begin
      if (c > 0) @(negedge clk);
      in_valid = 0; bus_gnt = 0;
      if (chk_ack) begin inj_ack = ack_valid && ack_addr == inj_a; chk_ack = 0; end
      if (cpu_done) begin
        fin_o = 1; rdv = cpu_rdata;
      end else begin
        #1;
        if (cpu_ready) rdy_leak = 1;
        if (bus_req && waited < gdelay) begin
          waited++; waiting = 1;
          if (out_valid) hold_fail = 1;
        end else if (bus_req) begin
          bus_gnt = 1; #1;
          waited = 0; waiting = 0;
          if (!out_valid) hold_fail = 1;
          else if (nmsg < 4) begin
            lt[nmsg] = out_type; la[nmsg] = out_addr; ld[nmsg] = out_data; nmsg++;
            sq_n = 0; sq_i = 0;
            if (inj && out_type != M_WB) begin sq_t[sq_n] = M_INV; sq_a[sq_n] = inj_a; sq_n++; end
            if (out_type == M_RD) begin sq_t[sq_n] = M_RESP; sq_a[sq_n] = a; sq_n++; end
            else if (out_type == M_INV || out_type == M_RDINV) begin
              if (out_type == M_RDINV && !ackfirst) begin sq_t[sq_n] = M_RESP; sq_a[sq_n] = a; sq_n++; end
              for (int k = 0; k < NPEER; k++) begin sq_t[sq_n] = M_ACK; sq_a[sq_n] = a; sq_n++; end
              if (out_type == M_RDINV && ackfirst) begin sq_t[sq_n] = M_RESP; sq_a[sq_n] = a; sq_n++; end
            end
          end
        end else begin
          if (waiting) hold_fail = 1;
          if (sq_i < sq_n) begin
            in_valid = 1; in_type = sq_t[sq_i]; in_addr = sq_a[sq_i];
            in_data = rsp; in_shared = sh;
            if (sq_t[sq_i] == M_INV) chk_ack = 1;
            sq_i++;
          end
        end
      end
    end
    in_valid = 0; bus_gnt = 0;
  endtask

  task automatic snoop(input logic [2:0] t, input logic [AW-1:0] a);
    @(negedge clk);
    in_valid = 1; in_type = t; in_addr = a; in_data = '0; in_shared = 0;
    @(negedge clk);
    in_valid = 0;
    sav = ack_valid; saa = ack_addr; sdv = dresp_valid; sdd = dresp_data;
  endtask

  initial begin
    #400000;
    nvec++; nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 ready after reset", cpu_ready, 1);
    chk("R1 no bus_req after reset", bus_req, 0);
    chk("R1 no done/ack/dresp after reset", {cpu_done, ack_valid, dresp_valid}, 0);

    for (int idx = 0; idx < 4; idx++) begin
      logic [AW-1:0] a_ad, b_ad, x_ad;
      logic [DW-1:0] d [10];
      a_ad = {6'(3 + idx), 2'(idx)};
      b_ad = {6'(40 + idx), 2'(idx)};
      x_ad = {6'h3E, 2'(idx)};
      for (int k = 0; k < 10; k++) d[k] = 16'(k * 4096 + idx * 257 + 3);

      do_op(0, a_ad, '0, 0, d[1], 0, idx, 0, '0);
      chk("R1 first read misses: msg count", nmsg, 1);
      chk("R3 read miss sends read", {lt[0], la[0]}, {M_RD, a_ad});
      chk("R3 read miss returns response data", rdv, d[1]);
      chk("R10 ready low while miss pending", rdy_leak, 0);
      chk("R11 bus_req held, no message before grant", hold_fail, 0);

      do_op(0, a_ad, '0, 0, '0, 0, 0, 0, '0);
      chk("R2 read hit silent", nmsg, 0);
      chk("R2 read hit data", rdv, d[1]);

      do_op(1, a_ad, d[2], 0, '0, 0, 0, 0, '0);
      chk("R4 write hit on Exclusive silent", nmsg, 0);
      chk("R4 write hit completes", fin_o, 1);

      snoop(M_RD, a_ad);
      chk("R8 snooped read on Modified gives data", {sdv, sdd}, {1'b1, d[2]});
      chk("R8 snooped read not acked", sav, 0);
      chk("R8 dresp address", dresp_addr, a_ad);

      do_op(1, a_ad, d[3], 0, '0, 0, 0, 0, '0);
      chk("R5 write to Shared sends invalidate", {nmsg[7:0], lt[0], la[0]}, {8'd1, M_INV, a_ad});
      chk("R5 upgrade completes after acks", fin_o, 1);

      do_op(0, a_ad, '0, 0, '0, 0, 0, 0, '0);
      chk("R5 line holds new word after upgrade", {nmsg[7:0], rdv}, {8'd0, d[3]});

      do_op(1, b_ad, d[4], 0, d[9], idx[0], 1, idx[1], x_ad);
      chk("R7 Modified victim writeback first", {nmsg[7:0], lt[0], la[0], ld[0]}, {8'd2, M_WB, a_ad, d[3]});
      chk("R6 write miss sends read-invalidate", {lt[1], la[1]}, {M_RDINV, b_ad});
      chk("R11 grant wait on two messages", hold_fail, 0);
      chk("R10 ready low during write miss", rdy_leak, 0);
      if (idx[1]) chk("R10 snoop acked while stalled", inj_ack, 1);

      snoop(M_RDINV, b_ad);
      chk("R9 read-invalidate acked", {sav, saa}, {1'b1, b_ad});
      chk("R6 installed Modified with write data", {sdv, sdd}, {1'b1, d[4]});

      do_op(0, b_ad, '0, 1, d[5], 0, 0, 0, '0);
      chk("R9 line dropped, read misses", {nmsg[7:0], lt[0]}, {8'd1, M_RD});
      chk("R3 shared response data", rdv, d[5]);

      do_op(1, b_ad, d[6], 0, '0, 0, 0, 0, '0);
      chk("R3 installed Shared: write sends invalidate", {nmsg[7:0], lt[0]}, {8'd1, M_INV});

      snoop(M_INV, b_ad);
      chk("R9 invalidate acked, no data", {sav, saa, sdv}, {1'b1, b_ad, 1'b0});

      do_op(0, b_ad, '0, 0, d[7], 0, 0, 0, '0);
      chk("R9 invalidated line misses", {nmsg[7:0], lt[0], rdv}, {8'd1, M_RD, d[7]});

      snoop(M_RD, b_ad);
      chk("R8 snooped read on Exclusive gives no data", {sdv, sav}, 0);

      do_op(1, b_ad, d[8], 0, '0, 0, 0, 0, '0);
      chk("R8 Exclusive became Shared", {nmsg[7:0], lt[0]}, {8'd1, M_INV});

      snoop(M_RD, b_ad);
      chk("R8 Modified after upgrade supplies data", {sdv, sdd}, {1'b1, d[8]});

      do_op(1, a_ad, d[9], 0, d[0], 0, 0, 0, '0);
      chk("R7 Shared victim dropped silently", {nmsg[7:0], lt[0], la[0]}, {8'd1, M_RDINV, a_ad});

      snoop(M_INV, x_ad);
      chk("R9 ack for line not held", {sav, saa, sdv}, {1'b1, x_ad, 1'b0});
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule